// File: doc/BRIEF.md
# Card Command Issue Controller

This block runs one card command from start to finish for a memory-card host. Software writes a 32-bit command word and a 32-bit argument. The command word carries the command index plus flags that pick the optional phases. A set start bit launches the sequence. The sequence may wait for an earlier data transfer to finish, then send an initialisation clock burst, then send the command. After that it can receive a response, supervise a data phase and send an automatic stop command. A clock-update-only command skips all card-bus activity: it pulses a clock-reload strobe and then completes.

The bit-level serialiser is a separate block. This controller talks to it through request/done handshakes:
- the transmit side takes an index, an argument and an abort flag;
- the receive side returns response bits with timeout and CRC-error flags.

The controller reports its outcome through one-cycle event pulses and through four stored 32-bit response words. It clears the start bit when the command is finished, so software can poll that bit.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: Writing a command word with bit 31 set launches a command. The written word reads back unchanged on the command readback port while the command runs. Bit 31 drops to 0 on the clock edge where the sequence finishes.
- R2: While bit 31 of the stored command is set, writes to the command word and to the argument are ignored.
- R3: With bit 21 set, the block pulses `clk_load` for exactly one cycle, one cycle after launch. It raises no transmit, receive or initialisation activity and no event, and it clears bit 31 on the following edge.
- R4: With bit 13 set and `data_busy` high, the command send is held off until `data_busy` falls. With bit 13 clear, `data_busy` has no effect.
- R5: With bit 15 set, `init_active` stays high for exactly INIT_CYCLES (default 80) consecutive cycles, and `tx_req` rises in the cycle after it falls.
- R6: During the send phase, `tx_req` is high and carries:
  - the index from bits 5:0 on `tx_index`;
  - the argument on `tx_arg`;
  - bit 14 on `tx_abort`.
  If bit 6 and bit 9 are both clear, `ev_cmd_done` pulses in the cycle after `tx_done`.
- R7: With bit 6 set, `rx_req` follows the send phase and `rx_long` equals bit 7. When `rx_done` arrives without a timeout:
  - a long response stores all four words, with word 3 in bits 127:96 as the most significant word;
  - a short response stores only word 0 from `rx_data[31:0]`, and words 1 to 3 keep their values;
  - `ev_cmd_done` pulses.
- R8: `ev_resp_crc` pulses together with `ev_cmd_done` only when bit 8 is set and `rx_crc_err` is high at `rx_done`. With bit 8 clear, a CRC error is ignored.
- R9: A response timeout pulses `ev_resp_timeout`, and `ev_cmd_done` pulses in the next cycle. The stored response is not changed, and the data phase is skipped.
- R10: With bit 9 set, `data_active` is high after the command phase until `data_over_in` arrives, and `data_write` equals bit 10. `ev_data_over` pulses in the cycle after `data_over_in`.
- R11: With bit 12 set, the end of the data phase starts a stop command: `tx_index` = 12, `tx_arg` = 0, `tx_abort` = 1. A short response is then received and is not stored, and `ev_auto_done` pulses after its `rx_done`.
- R12: After reset the command readback, the stored response words, all requests and all events are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument to write |
| cmd_rdata | output | 32 | Stored command word, start bit live |
| data_busy | input | 1 | An earlier data transfer is still running |
| clk_load | output | 1 | One-cycle strobe to reload clock settings |
| init_active | output | 1 | Initialisation clock burst running |
| tx_req | output | 1 | Request to serialise a command |
| tx_index | output | 6 | Command index to send |
| tx_arg | output | 32 | Command argument to send |
| tx_abort | output | 1 | Command being sent is a stop/abort |
| tx_done | input | 1 | Serialiser finished sending |
| rx_req | output | 1 | Request to receive a response |
| rx_long | output | 1 | Expected response is 136 bits |
| rx_done | input | 1 | Response reception ended |
| rx_timeout | input | 1 | Reception ended by timeout |
| rx_crc_err | input | 1 | Received response failed CRC |
| rx_data | input | 128 | Received response payload |
| data_active | output | 1 | Data phase in progress |
| data_write | output | 1 | Data phase direction is write |
| data_over_in | input | 1 | Data path reports transfer end |
| ev_cmd_done | output | 1 | Command-done pulse |
| ev_auto_done | output | 1 | Automatic stop completed pulse |
| ev_resp_timeout | output | 1 | Response timeout pulse |
| ev_resp_crc | output | 1 | Response CRC error pulse |
| ev_data_over | output | 1 | Data phase ended pulse |
| resp_words | output | 128 | Four stored response words, word 0 lowest |

## Verification
The assertions assume the neighbours answer only what was asked: `tx_done` comes only while `tx_req` is high, `rx_done` with its flags only while `rx_req` is high, and `data_over_in` only while `data_active` is high. Each done input lasts one cycle. The stimulus follows this by polling the request outputs before it raises any done input and by dropping that input after a single edge. The one deliberate breach of software etiquette is a write issued while a command is still running, which the block must ignore.

// File: rtl/cmdc_pkg.sv
// Shared types for the command issue controller.
// Assumes a 32-bit command word; flag positions are fixed by software.
package cmdc_pkg;
    localparam int CMD_W = 32;
    localparam logic [5:0] STOP_INDEX = 6'd12;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_INIT, ST_SEND, ST_RECV,
        ST_TDONE, ST_DATA, ST_ASEND, ST_ARECV, ST_CLK
    } cmdc_state_t;

    typedef struct packed {
        logic       start;
        logic       clk_only;
        logic       init_seq;
        logic       abort;
        logic       wait_prev;
        logic       auto_stop;
        logic       write;
        logic       has_data;
        logic       crc_chk;
        logic       long_rsp;
        logic       rsp;
        logic [5:0] index;
    } cmdc_fields_t;

    // Split a command word into its control flags.
    function automatic cmdc_fields_t decode_cmd(input logic [CMD_W-1:0] w);
        cmdc_fields_t f;
        f.start     = w[31];
        f.clk_only  = w[21];
        f.init_seq  = w[15];
        f.abort     = w[14];
        f.wait_prev = w[13];
        f.auto_stop = w[12];
        f.write     = w[10];
        f.has_data  = w[9];
        f.crc_chk   = w[8];
        f.long_rsp  = w[7];
        f.rsp       = w[6];
        f.index     = w[5:0];
        return f;
    endfunction
endpackage

// File: rtl/cmdc_burst_cnt.sv
// Initialisation burst counter: while run is high it counts cycles and
// flags the last one of COUNT. Assumes run stays high until last is seen.
module cmdc_burst_cnt #(
    parameter int COUNT = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int W = $clog2(COUNT + 1);
    localparam logic [W-1:0] CNT_LAST = W'(COUNT - 1);

    logic [W-1:0] cnt;

    // Count while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == CNT_LAST);

    // R5: the burst never runs past its configured length.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CNT_LAST));
endmodule

// File: rtl/cmdc_resp_store.sv
// Response word store: word 0 takes every accepted response, the upper
// words only long ones. Assumes din holds word 0 in its lowest bits.
module cmdc_resp_store #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     we_long,
    input  logic [WORD_W*WORDS-1:0]  din,
    output logic [WORD_W*WORDS-1:0]  dout
);
    localparam int TOT = WORD_W * WORDS;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam bit LOW_WORD = (g == 0);
        logic [WORD_W-1:0] word_q;

        // Capture this word when the response size covers it.
        always_ff @(posedge clk) begin
            if (!rst_n)                          word_q <= '0;
            else if (we && (LOW_WORD || we_long)) word_q <= din[g*WORD_W +: WORD_W];
        end

        assign dout[g*WORD_W +: WORD_W] = word_q;
    end

    // R7: a short response leaves the upper words alone.
    a_r7_short_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !we_long) |=> (dout[TOT-1:WORD_W] == $past(dout[TOT-1:WORD_W])));
endmodule

// File: rtl/cmdc_seq.sv
// Command sequencer: walks wait, init, send, receive, data and auto-stop
// phases as selected by the flags. Assumes each done input is a one-cycle
// pulse given only while the matching request is high.
module cmdc_seq
    import cmdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clk_only,
    input  logic wait_prev,
    input  logic init_seq,
    input  logic rsp,
    input  logic has_data,
    input  logic auto_stop,
    input  logic crc_chk,
    input  logic data_busy,
    input  logic burst_last,
    input  logic tx_done,
    input  logic rx_done,
    input  logic rx_timeout,
    input  logic rx_crc_err,
    input  logic data_over_in,
    output logic finish,
    output logic clk_load,
    output logic init_run,
    output logic tx_req,
    output logic stop_phase,
    output logic rx_req,
    output logic data_active,
    output logic resp_we,
    output logic ev_cmd_done,
    output logic ev_auto_done,
    output logic ev_resp_timeout,
    output logic ev_resp_crc,
    output logic ev_data_over
);
    cmdc_state_t state, nxt;
    cmdc_state_t lead;
    logic rsp_ok;

    assign lead   = init_seq ? ST_INIT : ST_SEND;
    assign rsp_ok = (state == ST_RECV) && rx_done && !rx_timeout;

    // Next-state selection for each phase.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) begin
                          if (clk_only)                    nxt = ST_CLK;
                          else if (wait_prev && data_busy) nxt = ST_WAIT;
                          else                             nxt = lead;
                      end
            ST_WAIT:  if (!data_busy) nxt = lead;
            ST_INIT:  if (burst_last) nxt = ST_SEND;
            ST_SEND:  if (tx_done) nxt = rsp ? ST_RECV : (has_data ? ST_DATA : ST_IDLE);
            ST_RECV:  if (rx_done) nxt = rx_timeout ? ST_TDONE : (has_data ? ST_DATA : ST_IDLE);
            ST_TDONE: nxt = ST_IDLE;
            ST_DATA:  if (data_over_in) nxt = auto_stop ? ST_ASEND : ST_IDLE;
            ST_ASEND: if (tx_done) nxt = ST_ARECV;
            ST_ARECV: if (rx_done) nxt = ST_IDLE;
            ST_CLK:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign finish      = (state != ST_IDLE) && (nxt == ST_IDLE);
    assign clk_load    = (state == ST_CLK);
    assign init_run    = (state == ST_INIT);
    assign stop_phase  = (state == ST_ASEND) || (state == ST_ARECV);
    assign tx_req      = (state == ST_SEND) || (state == ST_ASEND);
    assign rx_req      = (state == ST_RECV) || (state == ST_ARECV);
    assign data_active = (state == ST_DATA);
    assign resp_we     = rsp_ok;

    // Registered one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_cmd_done     <= 1'b0;
            ev_auto_done    <= 1'b0;
            ev_resp_timeout <= 1'b0;
            ev_resp_crc     <= 1'b0;
            ev_data_over    <= 1'b0;
        end else begin
            ev_cmd_done     <= ((state == ST_SEND) && tx_done && !rsp) || rsp_ok
                               || (state == ST_TDONE);
            ev_resp_timeout <= (state == ST_RECV) && rx_done && rx_timeout;
            ev_resp_crc     <= rsp_ok && crc_chk && rx_crc_err;
            ev_data_over    <= (state == ST_DATA) && data_over_in;
            ev_auto_done    <= (state == ST_ARECV) && rx_done;
        end
    end

    // R9: a timeout is always followed by command done.
    a_r9_timeout_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        ev_resp_timeout |=> ev_cmd_done);
    // R4: no send while the wait on a busy data path is held.
    a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && data_busy) |=> !tx_req);
    // R8: a CRC event only ever comes with command done.
    a_r8_crc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ev_resp_crc |-> ev_cmd_done);
endmodule

// File: rtl/cmd_issue_ctrl.sv
// Card command issue controller top: holds the command and argument words,
// decodes the flags, drives the serialiser handshakes through the sequencer
// and keeps the response words. Assumes handshake inputs obey the requests.
module cmd_issue_ctrl
    import cmdc_pkg::*;
#(
    parameter int INIT_CYCLES = 80,
    parameter int RESP_WORDS  = 4,
    parameter int WORD_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_wr,
    input  logic [31:0]                  cmd_wdata,
    input  logic                         arg_wr,
    input  logic [31:0]                  arg_wdata,
    output logic [31:0]                  cmd_rdata,
    input  logic                         data_busy,
    output logic                         clk_load,
    output logic                         init_active,
    output logic                         tx_req,
    output logic [5:0]                   tx_index,
    output logic [31:0]                  tx_arg,
    output logic                         tx_abort,
    input  logic                         tx_done,
    output logic                         rx_req,
    output logic                         rx_long,
    input  logic                         rx_done,
    input  logic                         rx_timeout,
    input  logic                         rx_crc_err,
    input  logic [RESP_WORDS*WORD_W-1:0] rx_data,
    output logic                         data_active,
    output logic                         data_write,
    input  logic                         data_over_in,
    output logic                         ev_cmd_done,
    output logic                         ev_auto_done,
    output logic                         ev_resp_timeout,
    output logic                         ev_resp_crc,
    output logic                         ev_data_over,
    output logic [RESP_WORDS*WORD_W-1:0] resp_words
);
    logic [CMD_W-1:0] cmd_q;
    logic [31:0]      arg_q;
    cmdc_fields_t     f;
    logic finish, init_run, burst_last, stop_phase, resp_we;

    assign f = decode_cmd(cmd_q);

    // Command word: locked while running, start bit cleared at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cmd_q     <= '0;
        else if (finish)                 cmd_q[31] <= 1'b0;
        else if (cmd_wr && !cmd_q[31])   cmd_q     <= cmd_wdata;
    end

    // Argument word: locked while a command runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                      arg_q <= '0;
        else if (arg_wr && !cmd_q[31])   arg_q <= arg_wdata;
    end

    cmdc_seq i_seq (
        .clk(clk), .rst_n(rst_n),
        .start(f.start), .clk_only(f.clk_only), .wait_prev(f.wait_prev),
        .init_seq(f.init_seq), .rsp(f.rsp), .has_data(f.has_data),
        .auto_stop(f.auto_stop), .crc_chk(f.crc_chk),
        .data_busy(data_busy), .burst_last(burst_last),
        .tx_done(tx_done), .rx_done(rx_done), .rx_timeout(rx_timeout),
        .rx_crc_err(rx_crc_err), .data_over_in(data_over_in),
        .finish(finish), .clk_load(clk_load), .init_run(init_run),
        .tx_req(tx_req), .stop_phase(stop_phase), .rx_req(rx_req),
        .data_active(data_active), .resp_we(resp_we),
        .ev_cmd_done(ev_cmd_done), .ev_auto_done(ev_auto_done),
        .ev_resp_timeout(ev_resp_timeout), .ev_resp_crc(ev_resp_crc),
        .ev_data_over(ev_data_over)
    );

    cmdc_burst_cnt #(.COUNT(INIT_CYCLES)) i_burst (
        .clk(clk), .rst_n(rst_n), .run(init_run), .last(burst_last)
    );

    cmdc_resp_store #(.WORD_W(WORD_W), .WORDS(RESP_WORDS)) i_resp (
        .clk(clk), .rst_n(rst_n), .we(resp_we), .we_long(f.long_rsp),
        .din(rx_data), .dout(resp_words)
    );

    assign cmd_rdata   = cmd_q;
    assign init_active = init_run;
    assign tx_index    = stop_phase ? STOP_INDEX : f.index;
    assign tx_arg      = stop_phase ? 32'd0 : arg_q;
    assign tx_abort    = stop_phase || f.abort;
    assign rx_long     = !stop_phase && f.long_rsp;
    assign data_write  = data_active && f.write;

    // R2: a write during a running command leaves the word unchanged.
    a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[31] && cmd_wr && !finish) |=> (cmd_rdata == $past(cmd_rdata)));
    // R1: the start bit stays set until the sequence finishes.
    a_r1_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[31] && !finish) |=> cmd_rdata[31]);
    // R3: a clock reload ends the command on the next edge.
    a_r3_clk_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        clk_load |=> !cmd_rdata[31]);
    // R10: the data phase only runs for commands that carry data.
    a_r10_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
        data_active |-> cmd_rdata[9]);
endmodule

// File: tb/test_cmd_issue_ctrl.sv
`timescale 1ns/1ps
module test_cmd_issue_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, arg_wr = 0;
    logic [31:0] cmd_wdata = 0, arg_wdata = 0;
    logic [31:0] cmd_rdata;
    logic data_busy = 0, clk_load, init_active;
    logic tx_req, tx_abort, tx_done = 0;
    logic [5:0] tx_index;
    logic [31:0] tx_arg;
    logic rx_req, rx_long, rx_done = 0, rx_timeout = 0, rx_crc_err = 0;
    logic [127:0] rx_data = 0;
    logic data_active, data_write, data_over_in = 0;
    logic ev_cmd_done, ev_auto_done, ev_resp_timeout, ev_resp_crc, ev_data_over;
    logic [127:0] resp_words;

    always #2.5 clk = ~clk;

    cmd_issue_ctrl i_cmd_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .cmd_rdata(cmd_rdata),
        .data_busy(data_busy), .clk_load(clk_load), .init_active(init_active),
        .tx_req(tx_req), .tx_index(tx_index), .tx_arg(tx_arg), .tx_abort(tx_abort),
        .tx_done(tx_done), .rx_req(rx_req), .rx_long(rx_long), .rx_done(rx_done),
        .rx_timeout(rx_timeout), .rx_crc_err(rx_crc_err), .rx_data(rx_data),
        .data_active(data_active), .data_write(data_write), .data_over_in(data_over_in),
        .ev_cmd_done(ev_cmd_done), .ev_auto_done(ev_auto_done),
        .ev_resp_timeout(ev_resp_timeout), .ev_resp_crc(ev_resp_crc),
        .ev_data_over(ev_data_over), .resp_words(resp_words)
    );

    // Event vector order: {auto, data_over, crc, timeout, done}.
    localparam logic [4:0] E_DONE = 5'b00001, E_TOUT = 5'b00010, E_CRC = 5'b00100,
                           E_DOVR = 5'b01000, E_AUTO = 5'b10000;
    localparam logic [31:0] START = 32'h8000_0000;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string cur_req = "R12";
    logic [4:0] exp_ev = 0;
    logic [127:0] model_resp = 0;   // behavioural copy of expected response words
    logic [127:0] long_val = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one clock and compare the event pulses with the model every cycle.
    task automatic step();
        @(negedge clk);
        check({cur_req, " events"}, 128'({ev_auto_done, ev_data_over, ev_resp_crc,
                                           ev_resp_timeout, ev_cmd_done}), 128'(exp_ev));
        exp_ev = 0;
    endtask

    task automatic issue(input logic [31:0] cmd, input logic [31:0] arg);
        cmd_wdata = cmd; arg_wdata = arg; cmd_wr = 1; arg_wr = 1;
        step();
        cmd_wr = 0; arg_wr = 0;
    endtask

    task automatic send_ok(input logic [5:0] idx, input logic [31:0] arg, input logic abort);
        check({cur_req, " tx_req"}, 128'(tx_req), 128'(1));
        check({cur_req, " tx_index"}, 128'(tx_index), 128'(idx));
        check({cur_req, " tx_arg"}, 128'(tx_arg), 128'(arg));
        check({cur_req, " tx_abort"}, 128'(tx_abort), 128'(abort));
        tx_done = 1;
    endtask

    task automatic receive(input logic longr, input logic [127:0] d,
                           input logic tout, input logic crc);
        check({cur_req, " rx_req"}, 128'(rx_req), 128'(1));
        check({cur_req, " rx_long"}, 128'(rx_long), 128'(longr));
        rx_done = 1; rx_data = d; rx_timeout = tout; rx_crc_err = crc;
    endtask

    task automatic rx_clear();
        rx_done = 0; rx_timeout = 0; rx_crc_err = 0;
    endtask

    initial begin
        repeat (3) step();
        cur_req = "R12";
        check("R12 cmd_rdata", 128'(cmd_rdata), 0);
        check("R12 resp_words", resp_words, 0);
        check("R12 requests", 128'({tx_req, rx_req, init_active, clk_load, data_active}), 0);
        rst_n = 1;
        step();

        // R6 / R1: command without response.
        cur_req = "R6";
        issue(START | 32'h5, 32'h0000_A5A5);
        check("R1 start readback", 128'(cmd_rdata), 128'(START | 32'h5));
        step();
        check("R6 rx idle", 128'(rx_req), 0);
        send_ok(6'd5, 32'h0000_A5A5, 1'b0);
        exp_ev = E_DONE;
        step(); tx_done = 0;
        check("R1 start cleared", 128'(cmd_rdata), 128'(32'h5));
        check("R6 tx dropped", 128'(tx_req), 0);

        // R6: abort flag passes through (bit 14).
        cur_req = "R6";
        issue(START | 32'h4000 | 32'h7, 32'h1);
        step();
        send_ok(6'd7, 32'h1, 1'b1);
        exp_ev = E_DONE;
        step(); tx_done = 0;

        // R7: short response with CRC check.
        cur_req = "R7";
        issue(START | 32'h140 | 32'd17, 32'h22);
        step(); send_ok(6'd17, 32'h22, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'hFFFF, 32'h1234_5678}, 1'b0, 1'b0);
        exp_ev = E_DONE; model_resp[31:0] = 32'h1234_5678;
        step(); rx_clear();
        check("R7 short store", resp_words, model_resp);

        // R7: long response fills all words, word 3 on top.
        issue(START | 32'h1C0 | 32'd2, 32'h0);
        step(); send_ok(6'd2, 32'h0, 1'b0); step(); tx_done = 0;
        receive(1'b1, long_val, 1'b0, 1'b0);
        exp_ev = E_DONE; model_resp = long_val;
        step(); rx_clear();
        check("R7 long store", resp_words, model_resp);

        // R7: short after long keeps upper words.
        issue(START | 32'h40 | 32'd13, 32'h0);
        step(); send_ok(6'd13, 32'h0, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h0BAD_F00D}, 1'b0, 1'b0);
        exp_ev = E_DONE; model_resp[31:0] = 32'h0BAD_F00D;
        step(); rx_clear();
        check("R7 upper kept", resp_words, model_resp);

        // R8: CRC error reported only with bit 8.
        cur_req = "R8";
        issue(START | 32'h140 | 32'd3, 32'h0);
        step(); send_ok(6'd3, 32'h0, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h3}, 1'b0, 1'b1);
        exp_ev = E_DONE | E_CRC; model_resp[31:0] = 32'h3;
        step(); rx_clear();
        issue(START | 32'h40 | 32'd3, 32'h0);
        step(); send_ok(6'd3, 32'h0, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h4}, 1'b0, 1'b1);
        exp_ev = E_DONE; model_resp[31:0] = 32'h4;
        step(); rx_clear();
        check("R8 crc ignored store", resp_words, model_resp);

        // R9: timeout, then done; no store, no data phase.
        cur_req = "R9";
        issue(START | 32'h240 | 32'd8, 32'h0);
        step(); send_ok(6'd8, 32'h0, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'hDEAD_BEEF}, 1'b1, 1'b0);
        exp_ev = E_TOUT;
        step(); rx_clear();
        check("R9 no data phase", 128'(data_active), 0);
        exp_ev = E_DONE;
        step();
        check("R9 start cleared", 128'(cmd_rdata[31]), 0);
        check("R9 resp untouched", resp_words, model_resp);
        check("R9 data idle", 128'(data_active), 0);

        // R10: read data phase.
        cur_req = "R10";
        issue(START | 32'h240 | 32'd18, 32'h100);
        step(); send_ok(6'd18, 32'h100, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h900}, 1'b0, 1'b0);
        exp_ev = E_DONE; model_resp[31:0] = 32'h900;
        step(); rx_clear();
        check("R10 data_active", 128'(data_active), 1);
        check("R10 read dir", 128'(data_write), 0);
        step(); step();
        check("R10 data held", 128'(data_active), 1);
        data_over_in = 1; exp_ev = E_DOVR;
        step(); data_over_in = 0;
        check("R10 end", 128'({cmd_rdata[31], data_active}), 0);

        // R10 / R11: write data with automatic stop.
        cur_req = "R11";
        issue(START | 32'h1640 | 32'd25, 32'h200);
        step(); send_ok(6'd25, 32'h200, 1'b0); step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h777}, 1'b0, 1'b0);
        exp_ev = E_DONE; model_resp[31:0] = 32'h777;
        step(); rx_clear();
        check("R10 write dir", 128'(data_write), 1);
        data_over_in = 1; exp_ev = E_DOVR;
        step(); data_over_in = 0;
        check("R11 still running", 128'(cmd_rdata[31]), 1);
        send_ok(6'd12, 32'h0, 1'b1);
        step(); tx_done = 0;
        receive(1'b0, {96'h0, 32'h5555}, 1'b0, 1'b0);
        exp_ev = E_AUTO;
        step(); rx_clear();
        check("R11 stop resp not stored", resp_words, model_resp);
        check("R11 start cleared", 128'(cmd_rdata[31]), 0);

        // R4: wait for previous data only with bit 13.
        cur_req = "R4";
        data_busy = 1;
        issue(START | 32'h2000 | 32'd9, 32'h9);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R4 held off", 128'(tx_req), 0);
        end
        data_busy = 0;
        step();
        send_ok(6'd9, 32'h9, 1'b0);
        exp_ev = E_DONE;
        step(); tx_done = 0;
        data_busy = 1;
        issue(START | 32'd10, 32'hA);
        step();
        send_ok(6'd10, 32'hA, 1'b0);
        exp_ev = E_DONE;
        step(); tx_done = 0; data_busy = 0;

        // R5: initialisation burst length.
        cur_req = "R5";
        issue(START | 32'h8000, 32'h0);
        step();
        begin
            int n = 0;
            while (init_active && n < 1000) begin
                check("R5 no tx in burst", 128'(tx_req), 0);
                n++;
                step();
            end
            check("R5 burst length", 128'(n), 128'(80));
        end
        send_ok(6'd0, 32'h0, 1'b0);
        exp_ev = E_DONE;
        step(); tx_done = 0;

        // R3: clock update only.
        cur_req = "R3";
        issue(START | 32'h20_2000, 32'h0);
        step();
        check("R3 clk_load", 128'(clk_load), 1);
        check("R3 bus quiet", 128'({tx_req, rx_req, init_active}), 0);
        step();
        check("R3 clk_load single", 128'(clk_load), 0);
        check("R3 start cleared", 128'(cmd_rdata[31]), 0);

        // R2: writes ignored while running.
        cur_req = "R2";
        issue(START | 32'd3, 32'h3333);
        step();
        cmd_wdata = START | 32'h3F; arg_wdata = 32'hFFFF; cmd_wr = 1; arg_wr = 1;
        step(); cmd_wr = 0; arg_wr = 0;
        check("R2 cmd kept", 128'(cmd_rdata), 128'(START | 32'd3));
        send_ok(6'd3, 32'h3333, 1'b0);
        exp_ev = E_DONE;
        step(); tx_done = 0;

        step();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule